// File: doc/BRIEF.md
# Ranked Reserve-Owner Chain for One Line

This block keeps the coherency standing of a single line address across `NC` caches in a scheme where one dirty owner is backed by a numbered line of reserve holders. It processes one event per clock. The events are a read miss from a cache that does not hold the line, and the eviction of the line from some cache. For every cache it reports a state code, a reserve rank and whether that rank still counts as a real successor.

A read miss makes the requester the new owner. The previous owner drops to the first reserve rank, and every reserve rank moves one step further back. When the owner evicts the line, the first reserve takes over ownership. The block then pulses a flag telling the owner to drop its pending copy-back. If no live first reserve exists, the block pulses a copy-back request instead and leaves the line without an owner. Evicting a reserve holder breaks the chain at that point. Every holder ranked behind it keeps its label but no longer counts as a successor.

Top module: `succession_chain`

## Requirements
- R1: After reset every cache reads state 0 (invalid), rank 0 and live 0, and both pulse outputs are low.
- R2: A read miss from a cache that does not hold the line makes it the owner (state 2, rank 0). The old owner, if there is one, becomes a live reserve of rank 1 (state 3). Every reserve of rank i moves to rank i+1 and keeps its live flag.
- R3: A reserve whose rank would go above `K` becomes plain shared instead (state 1, rank 0, live 0).
- R4: When the owner is evicted and a live rank-1 reserve exists, that reserve becomes owner and the evicted cache becomes invalid. Every reserve of rank i ≥ 2 moves to rank i-1 and keeps its live flag. `wb_cancel_o` pulses for one cycle.
- R5: When the owner is evicted and no live rank-1 reserve exists, the evicted cache becomes invalid and no cache is owner afterwards. The other caches are unchanged, and `wb_req_o` pulses for one cycle.
- R6: Evicting a reserve of rank k makes that cache invalid. Every reserve of rank above k keeps its rank and state but has live cleared.
- R7: Evicting a plain shared holder invalidates only that cache. An eviction naming a cache that does not hold the line, a read miss from a cache that already holds it, and any id of `NC` or more all leave every output unchanged.
- R8: When `evict_vld` and `miss_vld` are both high, only the eviction is processed. `miss_rdy` is low in that cycle, and the read miss has no effect.
- R9: The state, rank, live and pulse outputs change only at the clock edge that samples the event, and the pulses last exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_vld | input | 1 | Read miss event valid |
| miss_id | input | IDW | Cache issuing the read miss |
| miss_rdy | output | 1 | Read miss accepted this cycle (low while an eviction is offered) |
| evict_vld | input | 1 | Eviction event valid |
| evict_id | input | IDW | Cache evicting the line |
| state_o | output | 2*NC | Per cache 2-bit code: 0 invalid, 1 shared, 2 owner, 3 reserve |
| rank_o | output | LW*NC | Per cache reserve rank, 0 unless reserve |
| live_o | output | NC | Per cache: reserve still in the unbroken chain |
| wb_cancel_o | output | 1 | Successor took ownership; drop pending copy-back |
| wb_req_o | output | 1 | Owner left with no successor; copy-back needed |

## Verification
Every result is registered once, so an event driven on a falling edge shows on all outputs at the next falling edge, one rising edge later. `miss_rdy` is combinational and is sampled in the same half-cycle that the inputs are driven. The bench drives an event, waits one rising edge, then compares every cache and both pulses against its own model at the following falling edge. It then clears the inputs, so each pulse is seen in exactly one sample and must be low in the next.

// File: rtl/succession_chain.sv
module succession_chain #(
  parameter int NC  = 6,
  parameter int K   = 3,
  parameter int IDW = $clog2(NC),
  parameter int LW  = $clog2(K + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_vld,
  input  logic [IDW-1:0]    miss_id,
  output logic              miss_rdy,
  input  logic              evict_vld,
  input  logic [IDW-1:0]    evict_id,
  output logic [2*NC-1:0]   state_o,
  output logic [LW*NC-1:0]  rank_o,
  output logic [NC-1:0]     live_o,
  output logic              wb_cancel_o,
  output logic              wb_req_o
);
  localparam logic [LW-1:0] KMAX = LW'(K);
  localparam logic [LW-1:0] ONE  = LW'(1);

  logic [NC-1:0]          hold, own, live;
  logic [NC-1:0][LW-1:0]  lab;
  logic [NC-1:0]          n_hold, n_own, n_live;
  logic [NC-1:0][LW-1:0]  n_lab;
  logic                   n_cancel, n_req;

  wire ev_ok = evict_vld && (32'(evict_id) < NC);
  wire mv_ok = miss_vld  && (32'(miss_id)  < NC);

  assign miss_rdy = !evict_vld;

  always_comb begin
    logic            succ;
    logic [IDW-1:0]  succ_id;
    logic [IDW-1:0]  e;
    logic [LW-1:0]   ek;
    n_hold = hold; n_own = own; n_live = live; n_lab = lab;
    n_cancel = 1'b0; n_req = 1'b0;
    succ = 1'b0; succ_id = '0;
    for (int i = 0; i < NC; i++)
      if (hold[i] && !own[i] && lab[i] == ONE && live[i]) begin
        succ = 1'b1; succ_id = IDW'(i);
      end
    e  = evict_id;
    ek = ev_ok ? lab[e] : '0;
    if (ev_ok && hold[e]) begin
      if (own[e]) begin
        if (succ) begin
          n_cancel = 1'b1;
          for (int i = 0; i < NC; i++) begin
            if (IDW'(i) == succ_id) begin
              n_own[i] = 1'b1; n_lab[i] = '0; n_live[i] = 1'b0;
            end else if (hold[i] && lab[i] > ONE) begin
              n_lab[i] = lab[i] - ONE;
            end
          end
        end else begin
          n_req = 1'b1;
        end
      end else if (ek != '0) begin
        for (int i = 0; i < NC; i++)
          if (hold[i] && lab[i] > ek) n_live[i] = 1'b0;
      end
      n_hold[e] = 1'b0; n_own[e] = 1'b0; n_lab[e] = '0; n_live[e] = 1'b0;
    end else if (!evict_vld && mv_ok && !hold[miss_id]) begin
      for (int i = 0; i < NC; i++) begin
        if (hold[i] && own[i]) begin
          n_own[i] = 1'b0; n_lab[i] = ONE; n_live[i] = 1'b1;
        end else if (hold[i] && lab[i] != '0) begin
          if (lab[i] == KMAX) begin
            n_lab[i] = '0; n_live[i] = 1'b0;
          end else begin
            n_lab[i] = lab[i] + ONE;
          end
        end
      end
      n_hold[miss_id] = 1'b1; n_own[miss_id] = 1'b1;
      n_lab[miss_id]  = '0;   n_live[miss_id] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold <= '0; own <= '0; live <= '0; lab <= '0;
      wb_cancel_o <= 1'b0; wb_req_o <= 1'b0;
    end else begin
      hold <= n_hold; own <= n_own; live <= n_live; lab <= n_lab;
      wb_cancel_o <= n_cancel; wb_req_o <= n_req;
    end
  end

  for (genvar i = 0; i < NC; i++) begin : g_out
    assign state_o[2*i +: 2] = !hold[i] ? 2'd0 : own[i] ? 2'd2 :
                               (lab[i] != '0) ? 2'd3 : 2'd1;
    assign rank_o[LW*i +: LW] = lab[i];
    assign live_o[i] = live[i];

    AST_LABEL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      lab[i] <= KMAX);                                                  // R3
    AST_OWNER_UNRANKED: assert property (@(posedge clk) disable iff (!rst_n)
      own[i] |-> (hold[i] && lab[i] == '0 && !live[i]));                // R2
  end

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(own) <= 1);                                              // R2
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_cancel_o && wb_req_o));                                        // R9
  AST_CANCEL_KEEPS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cancel_o |-> $countones(own) == 1);                              // R4
  AST_REQ_CLEARS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req_o |-> own == '0);                                            // R5
  AST_EVICT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (evict_vld && miss_vld && (32'(miss_id) < NC) && !hold[miss_id] && !(ev_ok && own[evict_id]))
      |=> !own[$past(miss_id)]);                                        // R8
endmodule

// File: tb/sim_succession_chain.sv
module sim_succession_chain;
  localparam int NC = 6, K = 3, IDW = 3, LW = 2;
  localparam time CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic miss_vld = 0, evict_vld = 0;
  logic [IDW-1:0] miss_id = 0, evict_id = 0;
  logic miss_rdy, wb_cancel_o, wb_req_o;
  logic [2*NC-1:0] state_o;
  logic [LW*NC-1:0] rank_o;
  logic [NC-1:0] live_o;

  succession_chain #(.NC(NC), .K(K), .IDW(IDW), .LW(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .miss_vld(miss_vld), .miss_id(miss_id),
    .miss_rdy(miss_rdy), .evict_vld(evict_vld), .evict_id(evict_id),
    .state_o(state_o), .rank_o(rank_o), .live_o(live_o),
    .wb_cancel_o(wb_cancel_o), .wb_req_o(wb_req_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0;
  int m_st[NC], m_rk[NC], m_lv[NC];
  int m_cancel = 0, m_req = 0;

  function automatic string apply(int mv, int mid, int ev, int eid);
    int succ = -1, ek;
    string tag = "R7";
    m_cancel = 0; m_req = 0;
    if (ev) begin
      if (eid < NC && m_st[eid] != 0) begin
        if (m_st[eid] == 2) begin
          for (int i = 0; i < NC; i++)
            if (m_st[i] == 3 && m_rk[i] == 1 && m_lv[i] == 1) succ = i;
          if (succ >= 0) begin
            tag = "R4"; m_cancel = 1;
            for (int i = 0; i < NC; i++)
              if (i == succ) begin m_st[i] = 2; m_rk[i] = 0; m_lv[i] = 0; end
              else if (m_st[i] == 3) m_rk[i] = m_rk[i] - 1;
          end else begin tag = "R5"; m_req = 1; end
        end else if (m_st[eid] == 3) begin
          tag = "R6"; ek = m_rk[eid];
          for (int i = 0; i < NC; i++) if (m_st[i] == 3 && m_rk[i] > ek) m_lv[i] = 0;
        end
        m_st[eid] = 0; m_rk[eid] = 0; m_lv[eid] = 0;
      end
      if (mv) tag = {tag, "/R8"};
    end else if (mv && mid < NC && m_st[mid] == 0) begin
      tag = "R2";
      for (int i = 0; i < NC; i++)
        if (m_st[i] == 2) begin m_st[i] = 3; m_rk[i] = 1; m_lv[i] = 1; end
        else if (m_st[i] == 3) begin
          if (m_rk[i] == K) begin m_st[i] = 1; m_rk[i] = 0; m_lv[i] = 0; tag = "R2/R3"; end
          else m_rk[i] = m_rk[i] + 1;
        end
      m_st[mid] = 2; m_rk[mid] = 0; m_lv[mid] = 0;
    end
    return tag;
  endfunction

  task automatic compare(string tag);
    for (int i = 0; i < NC; i++) begin
      total++;
      if (int'(state_o[2*i +: 2]) != m_st[i] || int'(rank_o[LW*i +: LW]) != m_rk[i]
          || int'(live_o[i]) != m_lv[i]) begin
        bad++;
        $display("FAIL %s cache %0d: state/rank/live got %0d/%0d/%0d exp %0d/%0d/%0d",
                 tag, i, state_o[2*i +: 2], rank_o[LW*i +: LW], live_o[i],
                 m_st[i], m_rk[i], m_lv[i]);
      end
    end
    total++;
    if (int'(wb_cancel_o) != m_cancel || int'(wb_req_o) != m_req) begin
      bad++;
      $display("FAIL %s/R9 pulses cancel/req got %0d/%0d exp %0d/%0d",
               tag, wb_cancel_o, wb_req_o, m_cancel, m_req);
    end
  endtask

  task automatic step(int mv, int mid, int ev, int eid);
    string tag;
    miss_vld = 1'(mv); miss_id = IDW'(mid); evict_vld = 1'(ev); evict_id = IDW'(eid);
    #1;
    total++;
    if (miss_rdy !== !ev) begin
      bad++; $display("FAIL R8 miss_rdy got %0d exp %0d", miss_rdy, !ev);
    end
    tag = apply(mv, mid, ev, eid);
    @(posedge clk); @(negedge clk);
    miss_vld = 0; evict_vld = 0;
    compare(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed = 32'h1234_5678;
    for (int i = 0; i < NC; i++) begin m_st[i] = 0; m_rk[i] = 0; m_lv[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    compare("R1");
    // Build T=4, ST1=3, ST2=2, ST3=1, cache 0 saturated to shared (R3)
    for (int c = 0; c < 5; c++) step(1, c, 0, 0);
    step(0, 0, 1, 2);   // R6 break at rank 2: cache 1 orphaned
    step(0, 0, 1, 4);   // R4 successor 3 takes over, cache 1 to rank 2 orphan
    step(0, 0, 1, 3);   // R5 no live rank 1: copy-back request
    step(0, 0, 0, 0);   // R9 idle: pulses fall
    step(1, 5, 1, 0);   // R8 evict wins
    step(0, 0, 1, 5);   // R7 non-holder evict
    step(1, 1, 0, 0);   // R7 miss from holder
    step(1, 7, 1, 6);   // R7 out-of-range ids
    for (int n = 0; n < 4000; n++) begin
      int mv, ev;
      seed = seed * 1103515245 + 12345;
      mv = (seed >>> 16) & 1;
      ev = ((seed >>> 17) & 3) == 0 ? 1 : 0;
      step(mv, (seed >>> 20) & 7, ev, (seed >>> 24) & 7);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule